// File: doc/BRIEF.md
# Video Memory Row Array with Four-Column Block Fill

This block is a synchronous model of a 16-bit-wide video frame-store array. Each row holds 512 words, and the words are organised as 128 groups of four neighbouring columns. Three kinds of access come in through one clocked command port:

- an ordinary word read;
- an ordinary word write;
- a block fill, which writes one preloaded 16-bit colour value into as many as four columns of a group in a single cycle.

A per-bit write mask, two byte enables and, for block fills only, a column mask shape every write. The column mask is carried on the data bus. Each of its bits selects one column of the group for one four-bit slice (quadrant) of the word.

A small state machine gates block fills. Its states are ST_UNARMED and ST_ARMED. The only transition, ARM, moves from ST_UNARMED to ST_ARMED on the first colour-register load. The machine then stays in ST_ARMED until reset. While the machine is in ST_UNARMED, block fills are dropped. The colour and write-mask registers are loaded through their own strobes, and a load takes effect from the next cycle.

Top module: `vram_block_writer`

## Requirements
- R1: After reset every stored word is zero, rd_valid is low, rd_data is zero, the write mask is all ones (nothing masked) and the state is ST_UNARMED.
- R2: cmd_op encodings are 00 idle, 01 read, 10 write, and 11 idle. A read of word (cmd_row, cmd_col) presents that word on rd_data one cycle later with rd_valid high. In every cycle that follows a non-read command, rd_valid is low.
- R3: A write with cmd_dsf low stores cmd_data into word (cmd_row, cmd_col). Only bits whose write-mask bit and byte enable are both 1 are changed.
- R4: A write with cmd_dsf high is a block fill. cmd_col[8:2] selects group k, which covers columns 4k to 4k+3, and cmd_col[1:0] has no effect.
- R5: In a block fill, cmd_data bit 4q+c enables column c of the group for quadrant q (bits 4q to 4q+3). A 0 leaves that quadrant of that column unchanged.
- R6: In a block fill, every enabled bit i takes bit i of the colour register.
- R7: A write-mask bit of 0 at position i keeps bit i unchanged in every column, for both kinds of write.
- R8: cmd_be[0] gates bits 7:0 and cmd_be[1] gates bits 15:8, for both kinds of write.
- R9: Block fills change nothing while the state is ST_UNARMED. The ARM transition happens on the first color_ld, and the state stays ST_ARMED until reset.
- R10: A colour or write-mask load takes effect from the next cycle. A write issued in the same cycle as a load uses the previous register values and the previous state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 00 idle, 01 read, 10 write, 11 idle |
| cmd_dsf | input | 1 | High on a write selects block fill |
| cmd_row | input | ROW_W | Row address |
| cmd_col | input | 9 | Column address |
| cmd_data | input | 16 | Write data, or column mask for a block fill |
| cmd_be | input | 2 | Byte enables, bit 0 for the low byte |
| color_ld | input | 1 | Load strobe for the colour register |
| color_in | input | 16 | Colour value to load |
| wmask_ld | input | 1 | Load strobe for the write-mask register |
| wmask_in | input | 16 | Write-mask value to load |
| rd_data | output | 16 | Read data, valid one cycle after a read |
| rd_valid | output | 1 | High in the cycle rd_data holds a fresh read |

## Verification
The bench aims a block fill at a column address whose low bits are non-zero. If those bits were decoded, the fill would land in the wrong group, or columns outside the group would change. It issues a fill before any colour load, and a fill in the same cycle as the first colour load. A design that armed too early, or that forwarded the new colour, would change memory in either case. Mixed column masks, write masks and byte enables are crossed against a reference model, which catches a swapped quadrant-to-column mapping or a mask applied to only one kind of write. A final read sweep of both rows shows that no stray word was disturbed.

// File: rtl/vram_pkg.sv
package vram_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    typedef enum logic {
        ST_UNARMED = 1'b0,
        ST_ARMED   = 1'b1
    } arm_state_e;

    localparam int COL_W  = 9;
    localparam int LANE_W = 2;
    localparam int BLK_W  = COL_W - LANE_W;
    localparam int LANES  = 1 << LANE_W;
    localparam int GROUPS = 1 << BLK_W;
endpackage

// File: rtl/vram_arm_fsm.sv
module vram_arm_fsm
    import vram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic color_ld,
    output logic armed
);
    arm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNARMED: if (color_ld) state_d = ST_ARMED;
            ST_ARMED:   state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        armed = (state_q == ST_ARMED);
    end
endmodule

// File: rtl/vram_regs.sv
module vram_regs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          color_ld,
    input  logic [DW-1:0] color_in,
    input  logic          wmask_ld,
    input  logic [DW-1:0] wmask_in,
    output logic [DW-1:0] color_q,
    output logic [DW-1:0] wmask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color_q <= '0;
            wmask_q <= '1;
        end else begin
            if (color_ld) color_q <= color_in;
            if (wmask_ld) wmask_q <= wmask_in;
        end
    end
endmodule

// File: rtl/vram_lane_decode.sv
module vram_lane_decode #(
    parameter int DW     = 16,
    parameter int LANES  = 4,
    parameter int LANE_W = 2,
    parameter int BYTES  = 2
) (
    input  logic                      is_wr,
    input  logic                      is_blk,
    input  logic                      armed,
    input  logic [LANE_W-1:0]         lane,
    input  logic [DW-1:0]             data,
    input  logic [DW-1:0]             color,
    input  logic [DW-1:0]             wmask,
    input  logic [BYTES-1:0]          be,
    output logic [LANES-1:0][DW-1:0]  we,
    output logic [DW-1:0]             wval
);
    localparam int QW = DW / LANES;
    localparam int BYTE_BITS = DW / BYTES;

    logic [DW-1:0] bmask;

    for (genvar i = 0; i < DW; i++) begin : g_bmask
        assign bmask[i] = be[i / BYTE_BITS];
    end

    for (genvar c = 0; c < LANES; c++) begin : g_col
        logic colsel;
        assign colsel = is_blk ? armed : (lane == LANE_W'(c));
        for (genvar i = 0; i < DW; i++) begin : g_bit
            logic bitsel;
            assign bitsel = is_blk ? data[QW * (i / QW) + c] : 1'b1;
            assign we[c][i] = is_wr & colsel & bitsel & wmask[i] & bmask[i];
        end
    end

    assign wval = is_blk ? color : data;
endmodule

// File: rtl/vram_store.sv
module vram_store #(
    parameter int DW    = 16,
    parameter int LANES = 4,
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int LW    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            idx,
    input  logic [LW-1:0]            lane,
    input  logic [LANES-1:0][DW-1:0] we,
    input  logic [DW-1:0]            wval,
    input  logic                     rd_en,
    output logic [DW-1:0]            rd_data,
    output logic                     rd_valid
);
    logic [DW-1:0] mem [DEPTH][LANES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                for (int c = 0; c < LANES; c++) begin
                    mem[a][c] <= '0;
                end
            end
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            for (int c = 0; c < LANES; c++) begin
                if (|we[c]) mem[idx][c] <= (mem[idx][c] & ~we[c]) | (wval & we[c]);
            end
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[idx][lane];
        end
    end
endmodule

// File: rtl/vram_block_writer.sv
module vram_block_writer
    import vram_pkg::*;
#(
    parameter int ROWS  = 2,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_dsf,
    input  logic [ROW_W-1:0] cmd_row,
    input  logic [8:0]       cmd_col,
    input  logic [15:0]      cmd_data,
    input  logic [1:0]       cmd_be,
    input  logic             color_ld,
    input  logic [15:0]      color_in,
    input  logic             wmask_ld,
    input  logic [15:0]      wmask_in,
    output logic [15:0]      rd_data,
    output logic             rd_valid
);
    localparam int DW    = 16;
    localparam int AW    = ROW_W + BLK_W;
    localparam int DEPTH = ROWS * GROUPS;

    op_e                     op;
    logic                    armed;
    logic [DW-1:0]           color_q, wmask_q;
    logic [LANES-1:0][DW-1:0] col_we;
    logic [DW-1:0]           wval;
    logic [AW-1:0]           idx;

    assign op  = op_e'(cmd_op);
    assign idx = {cmd_row, cmd_col[COL_W-1:LANE_W]};

    vram_arm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .color_ld (color_ld),
        .armed    (armed)
    );

    vram_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .color_ld (color_ld),
        .color_in (color_in),
        .wmask_ld (wmask_ld),
        .wmask_in (wmask_in),
        .color_q  (color_q),
        .wmask_q  (wmask_q)
    );

    vram_lane_decode #(.DW(DW), .LANES(LANES), .LANE_W(LANE_W), .BYTES(2)) u_dec (
        .is_wr  (op == OP_WR),
        .is_blk (cmd_dsf),
        .armed  (armed),
        .lane   (cmd_col[LANE_W-1:0]),
        .data   (cmd_data),
        .color  (color_q),
        .wmask  (wmask_q),
        .be     (cmd_be),
        .we     (col_we),
        .wval   (wval)
    );

    vram_store #(.DW(DW), .LANES(LANES), .DEPTH(DEPTH), .AW(AW), .LW(LANE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx),
        .lane     (cmd_col[LANE_W-1:0]),
        .we       (col_we),
        .wval     (wval),
        .rd_en    (op == OP_RD),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/vram_bw_chk.sv
module vram_bw_chk (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd_op,
    input logic              cmd_dsf,
    input logic [1:0]        cmd_be,
    input logic              rd_valid,
    input logic              armed,
    input logic [15:0]       wmask_q,
    input logic [3:0][15:0]  col_we
);
    logic [15:0] any_we;
    logic [3:0]  col_any;
    always_comb begin
        any_we = '0;
        for (int c = 0; c < 4; c++) begin
            any_we     = any_we | col_we[c];
            col_any[c] = |col_we[c];
        end
    end

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b01) |=> rd_valid);
    // R2
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != 2'b01) |=> !rd_valid);
    // R7
    wmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_we & ~wmask_q) == 16'h0);
    // R8
    be_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_be[0] |-> (any_we[7:0] == 8'h0));
    // R8
    be_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_be[1] |-> (any_we[15:8] == 8'h0));
    // R9
    unarmed_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && cmd_dsf) |-> (any_we == 16'h0));
    // R3
    single_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_dsf |-> ($countones(col_any) <= 1));
    // R9
    stay_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

bind vram_block_writer vram_bw_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_op   (cmd_op),
    .cmd_dsf  (cmd_dsf),
    .cmd_be   (cmd_be),
    .rd_valid (rd_valid),
    .armed    (armed),
    .wmask_q  (wmask_q),
    .col_we   (col_we)
);

// File: tb/test_vram_block_writer.sv
module test_vram_block_writer;
    localparam int ROWS = 2;
    localparam int NV   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        cmd_dsf = 1'b0;
    logic [0:0]  cmd_row = '0;
    logic [8:0]  cmd_col = '0;
    logic [15:0] cmd_data = '0;
    logic [1:0]  cmd_be = 2'b00;
    logic        color_ld = 1'b0;
    logic [15:0] color_in = '0;
    logic        wmask_ld = 1'b0;
    logic [15:0] wmask_in = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] mdl [ROWS][512];
    logic [15:0] color_m, wm_m;
    logic        armed_m;

    always #4 clk = ~clk;

    vram_block_writer #(.ROWS(ROWS)) i_vram_block_writer (.*);

    // op[30:29] dsf[28] row[27] col[26:18] data[17:2] be[1:0]
    localparam logic [30:0] VEC [NV] = '{
        {2'd2, 1'b0, 1'b0, 9'd3,   16'h1234, 2'b11},
        {2'd1, 1'b0, 1'b0, 9'd3,   16'h0000, 2'b00},
        {2'd2, 1'b1, 1'b0, 9'd6,   16'hF0A5, 2'b11},
        {2'd1, 1'b0, 1'b0, 9'd4,   16'h0000, 2'b00},
        {2'd1, 1'b0, 1'b0, 9'd5,   16'h0000, 2'b00},
        {2'd1, 1'b0, 1'b0, 9'd7,   16'h0000, 2'b00},
        {2'd2, 1'b1, 1'b1, 9'd511, 16'hFFFF, 2'b01},
        {2'd1, 1'b0, 1'b1, 9'd508, 16'h0000, 2'b00},
        {2'd2, 1'b1, 1'b1, 9'd9,   16'h3C69, 2'b10},
        {2'd1, 1'b0, 1'b1, 9'd10,  16'h0000, 2'b00},
        {2'd3, 1'b1, 1'b0, 9'd12,  16'hFFFF, 2'b11},
        {2'd1, 1'b0, 1'b0, 9'd12,  16'h0000, 2'b00}
    };

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_cmd(input logic [1:0] op, input logic dsf, input logic row,
                             input logic [8:0] col, input logic [15:0] d, input logic [1:0] be);
        if (op == 2'd2) begin
            if (!dsf) begin
                for (int i = 0; i < 16; i++)
                    if (wm_m[i] && be[i/8]) mdl[row][col][i] = d[i];
            end else if (armed_m) begin
                for (int c = 0; c < 4; c++)
                    for (int i = 0; i < 16; i++)
                        if (wm_m[i] && be[i/8] && d[4*(i/4)+c])
                            mdl[row][{col[8:2], 2'(c)}][i] = color_m[i];
            end
        end
    endtask

    task automatic step(input logic [1:0] op, input logic dsf, input logic row,
                        input logic [8:0] col, input logic [15:0] d, input logic [1:0] be,
                        input logic cl, input logic [15:0] cv, input logic wl, input logic [15:0] wv,
                        input string req);
        logic [15:0] exp;
        @(negedge clk);
        cmd_op = op; cmd_dsf = dsf; cmd_row = row; cmd_col = col; cmd_data = d; cmd_be = be;
        color_ld = cl; color_in = cv; wmask_ld = wl; wmask_in = wv;
        exp = mdl[row][col];
        @(posedge clk);
        model_cmd(op, dsf, row, col, d, be);
        if (cl) begin color_m = cv; armed_m = 1'b1; end
        if (wl) wm_m = wv;
        @(negedge clk);
        if (op == 2'd1) begin
            check(rd_valid == 1'b1, {req, " rd_valid"}, 16'(rd_valid), 16'h1);
            check(rd_data == exp, req, rd_data, exp);
        end else begin
            check(rd_valid == 1'b0, "R2 no read", 16'(rd_valid), 16'h0);
        end
        cmd_op = 2'd0; color_ld = 1'b0; wmask_ld = 1'b0;
    endtask

    task automatic rd(input logic row, input logic [8:0] col, input string req);
        step(2'd1, 1'b0, row, col, 16'h0, 2'b00, 1'b0, 16'h0, 1'b0, 16'h0, req);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < 512; c++) mdl[r][c] = '0;
        color_m = '0; wm_m = '1; armed_m = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset outputs
        check(rd_valid == 1'b0, "R1 rd_valid", 16'(rd_valid), 16'h0);
        check(rd_data == 16'h0, "R1 rd_data", rd_data, 16'h0);
        rd(1'b1, 9'd200, "R1 zero word");
        // R9 fill before any colour load is dropped (R1 write mask all ones)
        step(2'd2, 1'b1, 1'b0, 9'd0, 16'hFFFF, 2'b11, 1'b0, 16'h0, 1'b0, 16'h0, "R9");
        rd(1'b0, 9'd2, "R9 unarmed fill");
        step(2'd2, 1'b0, 1'b0, 9'd1, 16'hBEEF, 2'b11, 1'b0, 16'h0, 1'b0, 16'h0, "R1");
        rd(1'b0, 9'd1, "R1 R3 default mask write");
        // R10 same-cycle load and fill: uses old state, so no change
        step(2'd2, 1'b1, 1'b0, 9'd16, 16'hFFFF, 2'b11, 1'b1, 16'hC35A, 1'b0, 16'h0, "R10");
        rd(1'b0, 9'd17, "R10 same-cycle arm");
        // R6 R5 fill now armed
        step(2'd2, 1'b1, 1'b0, 9'd18, 16'h8421, 2'b11, 1'b0, 16'h0, 1'b0, 16'h0, "R6");
        for (int c = 16; c < 20; c++) rd(1'b0, 9'(c), "R5 R6 diagonal mask");
        // R10 same-cycle write-mask load: old mask (all ones) still applies
        step(2'd2, 1'b0, 1'b1, 9'd40, 16'hFFFF, 2'b11, 1'b0, 16'h0, 1'b1, 16'hF7EE, "R10");
        rd(1'b1, 9'd40, "R10 old write mask");
        step(2'd2, 1'b0, 1'b1, 9'd41, 16'hFFFF, 2'b11, 1'b0, 16'h0, 1'b0, 16'h0, "R7");
        rd(1'b1, 9'd41, "R7 R3 masked normal write");
        // table: R4 low bits ignored, R5 quadrants, R7 mask, R8 byte enables
        for (int v = 0; v < NV; v++) begin
            logic [30:0] e;
            e = VEC[v];
            step(e[30:29], e[28], e[27], e[26:18], e[17:2], e[1:0],
                 1'b0, 16'h0, 1'b0, 16'h0, "R4 R5 R7 R8 table");
        end
        // R8 normal write with only high byte enabled
        step(2'd2, 1'b0, 1'b0, 9'd100, 16'hFFFF, 2'b10, 1'b1, 16'h0F0F, 1'b1, 16'hFFFF, "R8");
        rd(1'b0, 9'd100, "R8 high byte only");
        step(2'd2, 1'b1, 1'b0, 9'd103, 16'hFFFF, 2'b01, 1'b0, 16'h0, 1'b0, 16'h0, "R8");
        rd(1'b0, 9'd101, "R8 fill low byte only");
        // sweep: R4 no stray writes outside targeted groups
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < 48; c++) rd(r[0], 9'(c), "R4 sweep");
        for (int c = 504; c < 512; c++) rd(1'b1, 9'(c), "R4 top group sweep");
        // R1 reset clears storage and state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < 512; c++) mdl[r][c] = '0;
        color_m = '0; wm_m = '1; armed_m = 1'b0;
        rd(1'b0, 9'd17, "R1 cleared after reset");
        step(2'd2, 1'b1, 1'b0, 9'd17, 16'hFFFF, 2'b11, 1'b0, 16'h0, 1'b0, 16'h0, "R9");
        rd(1'b0, 9'd17, "R9 unarmed after reset");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule